// File: doc/BRIEF.md
# Pulse Charge and Fine-Time Extractor

This block takes one digitized waveform at a time from a sampling front end. The waveform arrives as 12-bit samples tagged with a channel number, with one marker on its first sample and another on its last. The block subtracts a programmed pedestal from each sample and stores the result. It looks for the first pulse that rises above a programmed threshold. Once the waveform has ended, it emits one result record for that pulse.

The charge field of the record holds one of two values, chosen by a mode input. It is either the largest pedestal-corrected sample of the pulse or the sum of the pulse samples. The time field comes from a digital constant-fraction discriminator. The crossing level is the pulse peak scaled by a 4-bit fraction in sixteenths. The time is the position of that level between the two samples that bracket it on the leading edge, given in sixteenths of a sample period. A validity flag marks a time that could not be interpolated. Waveforms may be up to `DEPTH` samples long. The pedestal, threshold, fraction and mode inputs are expected to stay constant while a waveform is being captured.

Top module: `wfx_extract`

## Requirements
- R1: Each accepted sample is reduced by `cfg_baseline_i`. A sample at or below the pedestal becomes zero; no negative value ever appears.
- R2: A pulse starts at the first corrected sample strictly greater than `cfg_thresh_i`. A waveform with no such sample produces no record.
- R3: With `cfg_area_mode_i`=0 the charge is the largest corrected sample of the first pulse only.
- R4: With `cfg_area_mode_i`=1 the charge is the sum of corrected samples from the pulse start. The sum stops before the first later sample at or below the threshold, or includes every sample up to the end of the waveform. Later pulses are not counted.
- R5: The crossing level is peak × `cfg_frac_i` / 16. The crossing sample k is the lowest sample index from 0 upward whose corrected value × 16 is at least peak × `cfg_frac_i`.
- R6: For k ≥ 1, `rec_time_o` = (k−1)·16 + floor((peak·frac − 16·s[k−1]) / (s[k] − s[k−1])), where s is the corrected sample. `rec_time_ok_o` is 1 in this case.
- R7: When k = 0 (including a fraction of zero) there are not two leading-edge samples. The record then carries `rec_time_ok_o`=0 and `rec_time_o`=0, and the charge is still reported.
- R8: Each record is marked by `rec_valid_o` high for exactly one cycle. It carries the channel given on the first sample of the waveform. The record fields hold their values until the next record.
- R9: Sample 0 of a waveform is the beat with `smp_sow_i`=1. Beats with `smp_vld_i`=1 that fall outside an open waveform are ignored and produce no record.
- R10: After reset, `rec_valid_o`, `rec_charge_o`, `rec_time_o` and `rec_time_ok_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample beat present |
| smp_sow_i | input | 1 | First sample of a waveform |
| smp_eow_i | input | 1 | Last sample of a waveform |
| smp_chan_i | input | CH_W (6) | Channel number, taken on the first sample |
| smp_data_i | input | SMP_W (12) | Raw sample |
| cfg_baseline_i | input | SMP_W (12) | Pedestal subtracted from each sample |
| cfg_thresh_i | input | SMP_W (12) | Pulse threshold on corrected samples |
| cfg_frac_i | input | FRAC_W (4) | Constant fraction in sixteenths |
| cfg_area_mode_i | input | 1 | 0: peak charge, 1: summed charge |
| rec_valid_o | output | 1 | One-cycle record strobe |
| rec_chan_o | output | CH_W (6) | Channel of the record |
| rec_charge_o | output | SMP_W+log2(DEPTH) (20) | Peak or summed charge |
| rec_time_o | output | log2(DEPTH)+FRAC_W (12) | Crossing time in 1/16 sample units |
| rec_time_ok_o | output | 1 | Time field is interpolated and valid |

## Verification
The assertions check on every cycle that the record strobe lasts one cycle and that the record fields hold between strobes. They also check that a record flagged as having no valid time carries a zero time, that every record has a nonzero charge, and that a valid time never lies past the last sample. The directed scenarios cover the rest, because each needs a whole waveform to judge. These are the pedestal clamp, strict threshold comparison, peak against summed charge, first-pulse-only selection, the exact interpolated time (including a crossing that lands exactly on a sample and one near the end of a full-length record), the invalid-time cases, and rejection of beats outside a waveform.

// File: rtl/wfx_pkg.sv
`timescale 1ns/1ps
package wfx_pkg;
  typedef enum logic [1:0] {
    ST_CAP  = 2'd0,
    ST_SCAN = 2'd1,
    ST_DIV  = 2'd2
  } wfx_state_e;
endpackage

// File: rtl/wfx_front.sv
`timescale 1ns/1ps
module wfx_front #(
  parameter int SMP_W = 12,
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ACC_W = SMP_W + IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             vld_i,
  input  logic             sow_i,
  input  logic             eow_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic [SMP_W-1:0] baseline_i,
  input  logic [SMP_W-1:0] thresh_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [SMP_W-1:0] wr_data_o,
  output logic             done_o,
  output logic             found_o,
  output logic [SMP_W-1:0] peak_o,
  output logic [ACC_W-1:0] area_o
);
  logic             open_q, done_q, found_q, in_q;
  logic [IDX_W:0]   idx_q;
  logic [SMP_W-1:0] peak_q;
  logic [ACC_W-1:0] area_q;

  logic [SMP_W-1:0] adj;
  logic             acc, above, in_rng;
  logic [IDX_W:0]   cur_idx;
  logic             b_found, b_in, n_found, n_in;
  logic [SMP_W-1:0] b_peak, n_peak;
  logic [ACC_W-1:0] b_area, n_area;

  assign adj     = (data_i > baseline_i) ? data_i - baseline_i : '0;
  assign acc     = en_i & vld_i & (sow_i | open_q);
  assign cur_idx = sow_i ? '0 : idx_q;
  assign in_rng  = cur_idx < (IDX_W+1)'(DEPTH);
  assign above   = adj > thresh_i;

  always_comb begin
    b_found = sow_i ? 1'b0 : found_q;
    b_in    = sow_i ? 1'b0 : in_q;
    b_peak  = sow_i ? '0 : peak_q;
    b_area  = sow_i ? '0 : area_q;
    n_found = b_found;
    n_in    = b_in;
    n_peak  = b_peak;
    n_area  = b_area;
    if (in_rng) begin
      if (b_in) begin
        if (above) begin
          n_area = b_area + ACC_W'(adj);
          if (adj > b_peak) n_peak = adj;
        end else begin
          n_in = 1'b0;
        end
      end else if (!b_found && above) begin
        n_found = 1'b1;
        n_in    = 1'b1;
        n_peak  = adj;
        n_area  = ACC_W'(adj);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      in_q    <= 1'b0;
      idx_q   <= '0;
      peak_q  <= '0;
      area_q  <= '0;
    end else begin
      done_q <= acc & eow_i;
      if (acc) begin
        open_q  <= ~eow_i;
        idx_q   <= in_rng ? cur_idx + (IDX_W+1)'(1) : cur_idx;
        found_q <= n_found;
        in_q    <= n_in;
        peak_q  <= n_peak;
        area_q  <= n_area;
      end
    end
  end

  assign wr_en_o   = acc & in_rng;
  assign wr_idx_o  = cur_idx[IDX_W-1:0];
  assign wr_data_o = adj;
  assign done_o    = done_q;
  assign found_o   = found_q;
  assign peak_o    = peak_q;
  assign area_o    = area_q;
endmodule

// File: rtl/wfx_store.sv
`timescale 1ns/1ps
module wfx_store #(
  parameter int W     = 12,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/wfx_div.sv
`timescale 1ns/1ps
module wfx_div #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 12,
  parameter int QW    = 5,
  localparam int DW   = NUM_W + QW,
  localparam int CW   = $clog2(QW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [QW-1:0]    quo_o
);
  logic [DW-1:0] r_q, d_q;
  logic [QW-1:0] q_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  // restoring division, one quotient bit per cycle, MSB first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q    <= '0;
      d_q    <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        r_q    <= DW'(num_i);
        d_q    <= DW'(den_i) << (QW - 1);
        q_q    <= '0;
        cnt_q  <= CW'(QW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (r_q >= d_q) begin
          r_q <= r_q - d_q;
          q_q <= {q_q[QW-2:0], 1'b1};
        end else begin
          q_q <= {q_q[QW-2:0], 1'b0};
        end
        d_q   <= d_q >> 1;
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = q_q;
endmodule

// File: rtl/wfx_extract.sv
`timescale 1ns/1ps
module wfx_extract
  import wfx_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int DEPTH  = 256,
  parameter int CH_W   = 6,
  parameter int FRAC_W = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ACC_W  = SMP_W + IDX_W,
  localparam int LVL_W  = SMP_W + FRAC_W,
  localparam int TIME_W = IDX_W + FRAC_W,
  localparam int QW     = FRAC_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic              smp_sow_i,
  input  logic              smp_eow_i,
  input  logic [CH_W-1:0]   smp_chan_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  input  logic [SMP_W-1:0]  cfg_baseline_i,
  input  logic [SMP_W-1:0]  cfg_thresh_i,
  input  logic [FRAC_W-1:0] cfg_frac_i,
  input  logic              cfg_area_mode_i,
  output logic              rec_valid_o,
  output logic [CH_W-1:0]   rec_chan_o,
  output logic [ACC_W-1:0]  rec_charge_o,
  output logic [TIME_W-1:0] rec_time_o,
  output logic              rec_time_ok_o
);
  wfx_state_e        st_q;
  logic [IDX_W-1:0]  k_q;
  logic [CH_W-1:0]   chan_q;
  logic              area_mode_q;
  logic [FRAC_W-1:0] frac_q;

  logic              cap_en, acc_sow;
  logic              wr_en, wf_done, found;
  logic [IDX_W-1:0]  wr_idx;
  logic [SMP_W-1:0]  wr_data, peak, s_cur, s_prev;
  logic [ACC_W-1:0]  area;
  logic [LVL_W-1:0]  lvl, cur16, prev16;
  logic              hit, div_start, div_done;
  logic [QW-1:0]     div_quo;
  logic [IDX_W-1:0]  km1;
  logic [ACC_W-1:0]  charge;

  logic              rec_valid_q, rec_ok_q;
  logic [CH_W-1:0]   rec_chan_q;
  logic [ACC_W-1:0]  rec_charge_q;
  logic [TIME_W-1:0] rec_time_q;

  assign cap_en  = (st_q == ST_CAP) && !wf_done;
  assign acc_sow = smp_vld_i & smp_sow_i & cap_en;

  wfx_front #(.SMP_W(SMP_W), .DEPTH(DEPTH)) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cap_en),
    .vld_i      (smp_vld_i),
    .sow_i      (smp_sow_i),
    .eow_i      (smp_eow_i),
    .data_i     (smp_data_i),
    .baseline_i (cfg_baseline_i),
    .thresh_i   (cfg_thresh_i),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .done_o     (wf_done),
    .found_o    (found),
    .peak_o     (peak),
    .area_o     (area)
  );

  assign km1 = k_q - IDX_W'(1);

  wfx_store #(.W(SMP_W), .DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .we_i      (wr_en),
    .waddr_i   (wr_idx),
    .wdata_i   (wr_data),
    .raddr_a_i (k_q),
    .rdata_a_o (s_cur),
    .raddr_b_i (km1),
    .rdata_b_o (s_prev)
  );

  // level and samples kept in 1/16 units so the comparison is exact
  assign lvl       = LVL_W'(peak) * LVL_W'(frac_q);
  assign cur16     = {s_cur, {FRAC_W{1'b0}}};
  assign prev16    = {s_prev, {FRAC_W{1'b0}}};
  assign hit       = cur16 >= lvl;
  assign div_start = (st_q == ST_SCAN) && hit && (k_q != '0);
  assign charge    = area_mode_q ? area : ACC_W'(peak);

  wfx_div #(.NUM_W(LVL_W), .DEN_W(SMP_W), .QW(QW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .num_i   (lvl - prev16),
    .den_i   (s_cur - s_prev),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_CAP;
      k_q          <= '0;
      chan_q       <= '0;
      area_mode_q  <= 1'b0;
      frac_q       <= '0;
      rec_valid_q  <= 1'b0;
      rec_ok_q     <= 1'b0;
      rec_chan_q   <= '0;
      rec_charge_q <= '0;
      rec_time_q   <= '0;
    end else begin
      rec_valid_q <= 1'b0;
      if (acc_sow) begin
        chan_q      <= smp_chan_i;
        area_mode_q <= cfg_area_mode_i;
        frac_q      <= cfg_frac_i;
      end
      unique case (st_q)
        ST_CAP: begin
          if (wf_done && found) begin
            st_q <= ST_SCAN;
            k_q  <= '0;
          end
        end
        ST_SCAN: begin
          if (hit) begin
            if (k_q == '0) begin
              rec_valid_q  <= 1'b1;
              rec_chan_q   <= chan_q;
              rec_charge_q <= charge;
              rec_time_q   <= '0;
              rec_ok_q     <= 1'b0;
              st_q         <= ST_CAP;
            end else begin
              st_q <= ST_DIV;
            end
          end else begin
            k_q <= k_q + IDX_W'(1);
          end
        end
        ST_DIV: begin
          if (div_done) begin
            rec_valid_q  <= 1'b1;
            rec_chan_q   <= chan_q;
            rec_charge_q <= charge;
            rec_time_q   <= {km1, {FRAC_W{1'b0}}} + TIME_W'(div_quo);
            rec_ok_q     <= 1'b1;
            st_q         <= ST_CAP;
          end
        end
        default: st_q <= ST_CAP;
      endcase
    end
  end

  assign rec_valid_o   = rec_valid_q;
  assign rec_chan_o    = rec_chan_q;
  assign rec_charge_o  = rec_charge_q;
  assign rec_time_o    = rec_time_q;
  assign rec_time_ok_o = rec_ok_q;
endmodule

// File: rtl/wfx_extract_chk.sv
`timescale 1ns/1ps
module wfx_extract_chk #(
  parameter int SMP_W  = 12,
  parameter int DEPTH  = 256,
  parameter int CH_W   = 6,
  parameter int FRAC_W = 4,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ACC_W  = SMP_W + IDX_W,
  localparam int TIME_W = IDX_W + FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rec_valid_o,
  input logic [CH_W-1:0]   rec_chan_o,
  input logic [ACC_W-1:0]  rec_charge_o,
  input logic [TIME_W-1:0] rec_time_o,
  input logic              rec_time_ok_o
);
  localparam logic [TIME_W-1:0] TMAX = TIME_W'((DEPTH - 1) << FRAC_W);

  a_r8_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o);

  a_r8_charge_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_valid_o |-> $stable(rec_charge_o));

  a_r8_fields_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_valid_o |-> ($stable(rec_time_o) && $stable(rec_time_ok_o) && $stable(rec_chan_o)));

  a_r7_bad_time_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_time_ok_o) |-> (rec_time_o == '0));

  a_r2_charge_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_charge_o != '0));

  a_r6_time_in_record: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_time_ok_o) |-> (rec_time_o <= TMAX));
endmodule

bind wfx_extract wfx_extract_chk #(
  .SMP_W(SMP_W), .DEPTH(DEPTH), .CH_W(CH_W), .FRAC_W(FRAC_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rec_valid_o   (rec_valid_o),
  .rec_chan_o    (rec_chan_o),
  .rec_charge_o  (rec_charge_o),
  .rec_time_o    (rec_time_o),
  .rec_time_ok_o (rec_time_ok_o)
);

// File: tb/tb_wfx_extract.sv
`timescale 1ns/1ps
module tb_wfx_extract;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0, sow = 1'b0, eow = 1'b0;
  logic [5:0]  chan = '0;
  logic [11:0] data = '0;
  logic [11:0] bl = '0, thr = '0;
  logic [3:0]  frac = '0;
  logic        mode = 1'b0;
  logic        rv, rok;
  logic [5:0]  rch;
  logic [19:0] rchg;
  logic [11:0] rtm;

  int wf [DEPTH];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wfx_extract dut (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_vld_i(vld), .smp_sow_i(sow), .smp_eow_i(eow),
    .smp_chan_i(chan), .smp_data_i(data),
    .cfg_baseline_i(bl), .cfg_thresh_i(thr), .cfg_frac_i(frac), .cfg_area_mode_i(mode),
    .rec_valid_o(rv), .rec_chan_o(rch), .rec_charge_o(rchg),
    .rec_time_o(rtm), .rec_time_ok_o(rok)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference from the requirement text
  task automatic model(input int n, output bit f, output int chg, output bit ok, output int tm);
    int a [DEPTH];
    int pk, ar, k, lvl;
    bit inp;
    f = 0; inp = 0; pk = 0; ar = 0;
    for (int i = 0; i < n; i++) begin
      a[i] = (wf[i] > int'(bl)) ? wf[i] - int'(bl) : 0;
      if (inp) begin
        if (a[i] > int'(thr)) begin
          ar += a[i];
          if (a[i] > pk) pk = a[i];
        end else inp = 0;
      end else if (!f && a[i] > int'(thr)) begin
        f = 1; inp = 1; pk = a[i]; ar = a[i];
      end
    end
    chg = mode ? ar : pk;
    lvl = pk * int'(frac);
    k = 0;
    while (k < n && a[k] * 16 < lvl) k++;
    if (k == 0) begin ok = 0; tm = 0; end
    else begin ok = 1; tm = (k - 1) * 16 + (lvl - 16 * a[k-1]) / (a[k] - a[k-1]); end
  endtask

  task automatic send(int ch, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1; sow = (i == 0); eow = (i == n - 1); chan = 6'(ch); data = 12'(wf[i]);
    end
    @(negedge clk);
    vld = 0; sow = 0; eow = 0;
  endtask

  task automatic run_wf(string req, int ch, int n);
    bit f, ok, got;
    int chg, tm;
    model(n, f, chg, ok, tm);
    send(ch, n);
    got = 0;
    for (int c = 0; c < 2 * DEPTH + 40; c++) begin
      @(negedge clk);
      if (rv) begin got = 1; break; end
    end
    if (!f) begin
      check({req, " R2 no record"}, int'(got), 0);
      return;
    end
    check({req, " R8 record seen"}, int'(got), 1);
    if (!got) return;
    check({req, " R8 channel"}, int'(rch), ch);
    check({req, mode ? " R4 area charge" : " R3 peak charge"}, int'(rchg), chg);
    check({req, " R7 time ok"}, int'(rok), int'(ok));
    check({req, " R6 time"}, int'(rtm), tm);
    @(negedge clk);
    check({req, " R8 one-cycle strobe"}, int'(rv), 0);
    check({req, " R8 charge held"}, int'(rchg), chg);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_a();
    int v [10] = '{100, 100, 180, 500, 900, 700, 300, 120, 100, 90};
    for (int i = 0; i < 10; i++) wf[i] = v[i];
    bl = 100; thr = 50;
  endtask

  task automatic t_reset();
    check("R10 valid", int'(rv), 0);
    check("R10 charge", int'(rchg), 0);
    check("R10 time", int'(rtm), 0);
    check("R10 time ok", int'(rok), 0);
  endtask

  task automatic t_peak();       // exact on-sample crossing, time 48
    pulse_a(); mode = 0; frac = 8;
    run_wf("peak R5", 3, 10);
  endtask

  task automatic t_area();
    pulse_a(); mode = 1; frac = 6;
    run_wf("area R4", 12, 10);
  endtask

  task automatic t_clamp();
    int v [7] = '{250, 290, 700, 1300, 500, 310, 200};
    for (int i = 0; i < 7; i++) wf[i] = v[i];
    bl = 300; thr = 100; mode = 1; frac = 4;
    run_wf("clamp R1", 7, 7);
    mode = 0;
    run_wf("clamp R1 peak", 8, 7);
  endtask

  task automatic t_nopulse();    // corrected value equal to threshold is no pulse
    int v [5] = '{100, 150, 150, 20, 100};
    for (int i = 0; i < 5; i++) wf[i] = v[i];
    bl = 100; thr = 50; mode = 0; frac = 8;
    run_wf("equal thr R2", 1, 5);
  endtask

  task automatic t_edge0();
    int v [3] = '{900, 1200, 400};
    for (int i = 0; i < 3; i++) wf[i] = v[i];
    bl = 0; thr = 100; mode = 0; frac = 8;
    run_wf("first sample R7", 20, 3);
  endtask

  task automatic t_frac0();
    pulse_a(); mode = 0; frac = 0;
    run_wf("zero fraction R7", 21, 10);
  endtask

  task automatic t_two();
    int v [7] = '{0, 200, 300, 0, 500, 600, 0};
    for (int i = 0; i < 7; i++) wf[i] = v[i];
    bl = 0; thr = 100; frac = 8;
    mode = 1; run_wf("two pulses R4", 30, 7);
    mode = 0; run_wf("two pulses R3", 31, 7);
  endtask

  task automatic t_tail();
    int v [5] = '{0, 0, 100, 400, 900};
    for (int i = 0; i < 5; i++) wf[i] = v[i];
    bl = 0; thr = 50; mode = 1; frac = 10;
    run_wf("to end R4", 40, 5);
  endtask

  task automatic t_long();
    for (int i = 0; i < DEPTH; i++) wf[i] = 5;
    wf[250] = 300; wf[251] = 1200; wf[252] = 2000;
    wf[253] = 2500; wf[254] = 2600; wf[255] = 2600;
    bl = 0; thr = 100; frac = 12;
    mode = 0; run_wf("full length R6", 63, DEPTH);
    mode = 1; run_wf("full length R4", 62, DEPTH);
  endtask

  task automatic t_stray();
    int cnt;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      vld = 1; sow = 0; eow = (i == 5); chan = 6'd9; data = 12'd4000;
    end
    @(negedge clk);
    vld = 0; eow = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (rv) cnt++;
    end
    check("stray beats R9 no record", cnt, 0);
    pulse_a(); mode = 1; frac = 8;
    run_wf("after stray R9", 17, 10);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_peak();
    t_area();
    t_clamp();
    t_nopulse();
    t_edge0();
    t_frac0();
    t_two();
    t_tail();
    t_long();
    t_stray();
    summary();
  end
endmodule